// File: doc/BRIEF.md
# Step Attenuator Control Logic

This block is the digital control core of a six-step binary attenuator. It reads a six-bit active-low control word and reports the attenuation it applies as a six-bit code. Each code unit is one quarter of a decibel. A low control bit adds its weight to the total, so the reported code is the bitwise inverse of the control word. All inputs are asynchronous to the block clock, and each one passes through a two-flop synchronizer before the logic uses it.

After reset, the block waits through a settling period of `SETTLE_CYC` clock cycles. It reports code 0 and ignores its controls during that time. When the period ends, it loads its first state. If the latch enable is low at that moment, the two power-up select pins choose one of four fixed codes. If the latch enable is high, the first state is taken from the control word. After that first load, parallel operation applies while the serial select is low. Holding the latch enable high lets the code follow the control word directly. Holding it low freezes the code. A high pulse on the latch enable applies whatever word is present during the pulse. While the serial select is high, the last applied code is held. All pins are plain level controls with no handshake, because the block applies levels and transfers no data items, so there is no back-pressure.

Top module: `step_atten_ctrl`

## Requirements
- R1: While `rst_n` is low, `atten_code` is 0.
- R2: Before the settling period ends, `atten_code` stays 0 whatever `ctl_n`, `latch`, `serial_sel`, `pwr_sel0` or `pwr_sel1` do.
- R3: If the synchronized `latch` is low when the settling period ends, the first code comes from the `{pwr_sel1,pwr_sel0}` pair: 00 gives 63 (15.75 dB), 01 gives 48 (12 dB), 10 gives 32 (8 dB), 11 gives 0.
- R4: If the synchronized `latch` is high when the settling period ends, the first code is `~ctl_n`.
- R5: After settling, while `serial_sel` is low and `latch` is high, `atten_code` follows `~ctl_n`. Bit 0 weighs 0.25 dB and bit 5 weighs 8 dB.
- R6: After settling, while `latch` is low, `atten_code` does not change, whatever `ctl_n` does.
- R7: A high pulse on `latch` of at least two clock cycles, while `serial_sel` is low, applies `~ctl_n` as it stands during the pulse. The code then holds after `latch` falls.
- R8: While `serial_sel` is high, `atten_code` holds its last applied value, even with `latch` high and `ctl_n` changing.
- R9: A change on an input that is sampled before a rising clock edge reaches `atten_code` after exactly three rising edges: two synchronizer stages and the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_n | input | 6 | Active-low attenuation control word |
| latch | input | 1 | Latch enable: high makes the word transparent, low holds the code |
| serial_sel | input | 1 | High freezes the parallel path |
| pwr_sel0 | input | 1 | Power-up select, low bit of the pair |
| pwr_sel1 | input | 1 | Power-up select, high bit of the pair |
| atten_code | output | 6 | Applied attenuation in 0.25 dB steps |

## Verification
Each result is due three rising edges after the stimulus is driven: two for the synchronizer and one for the code register. The first state is due on the edge that ends the settling count, which is `SETTLE_CYC` edges after reset release. The bench drives inputs on falling edges and counts whole clock periods before it samples on a falling edge. For R9, it also samples after only two edges to confirm that the old code is still present. Power-up cases hold their inputs steady for far longer than the synchronizer depth before the settling period ends, so the sampled latch level is never ambiguous.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int unsigned SAT_CODE_W     = 6;
  localparam int unsigned SAT_SETTLE_DEF = 50_000_000;

  // Encoding is {pwr_sel1, pwr_sel0}.
  typedef enum logic [1:0] {
    PUP_FULL = 2'b00,
    PUP_HIGH = 2'b01,
    PUP_MID  = 2'b10,
    PUP_ZERO = 2'b11
  } pup_sel_e;
endpackage

// File: rtl/sat_sync.sv
module sat_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end
      assign sync_o[b] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sat_settle.sv
module sat_settle #(
  parameter int unsigned SETTLE_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic expire,
  output logic settled
);
  localparam int unsigned CW   = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign expire  = !done_q && (cnt_q == LAST);
  assign settled = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (expire) done_q <= 1'b1;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  assert_settle_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> (cnt_q <= LAST));
endmodule

// File: rtl/sat_apply.sv
module sat_apply
  import sat_pkg::*;
#(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         expire,
  input  logic         settled,
  input  logic [W-1:0] word_n,
  input  logic         le,
  input  logic         ser,
  input  logic [1:0]   pup,
  output logic [W-1:0] atten
);
  function automatic logic [W-1:0] pup_code(input logic [1:0] sel);
    case (pup_sel_e'(sel))
      PUP_FULL: pup_code = '1;
      PUP_HIGH: pup_code = {2'b11, {(W-2){1'b0}}};
      PUP_MID:  pup_code = {1'b1, {(W-1){1'b0}}};
      default:  pup_code = '0;
    endcase
  endfunction

  logic [W-1:0] atten_q;
  logic [W-1:0] next_code;
  logic         load;

  always_comb begin
    load      = 1'b0;
    next_code = atten_q;
    if (expire) begin
      load      = 1'b1;
      next_code = le ? ~word_n : pup_code(pup);
    end else if (settled && !ser && le) begin
      load      = 1'b1;
      next_code = ~word_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    atten_q <= '0;
    else if (load) atten_q <= next_code;
  end

  assign atten = atten_q;

  assert_zero_until_settled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !settled |-> (atten_q == '0));
  assert_hold_latch_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(settled) && !$past(le)) |-> $stable(atten_q));
  assert_hold_serial_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(settled) && $past(ser)) |-> $stable(atten_q));
  assert_pup_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(expire) && !$past(le)) |->
      (atten_q == '1 || atten_q == '0 || atten_q == {2'b11, {(W-2){1'b0}}}
       || atten_q == {1'b1, {(W-1){1'b0}}}));
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import sat_pkg::*;
#(
  parameter int unsigned CODE_W     = SAT_CODE_W,
  parameter int unsigned SETTLE_CYC = SAT_SETTLE_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ctl_n,
  input  logic              latch,
  input  logic              serial_sel,
  input  logic              pwr_sel0,
  input  logic              pwr_sel1,
  output logic [CODE_W-1:0] atten_code
);
  localparam int unsigned SYNC_W = CODE_W + 4;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] syn;
  logic              expire;
  logic              settled;

  assign raw_in = {pwr_sel1, pwr_sel0, serial_sel, latch, ctl_n};

  sat_sync #(.WIDTH(SYNC_W), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(raw_in),
    .sync_o (syn)
  );

  sat_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .settled(settled)
  );

  sat_apply #(.W(CODE_W)) u_apply (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .settled(settled),
    .word_n (syn[CODE_W-1:0]),
    .le     (syn[CODE_W]),
    .ser    (syn[CODE_W+1]),
    .pup    (syn[CODE_W+3:CODE_W+2]),
    .atten  (atten_code)
  );
endmodule

// File: tb/step_atten_ctrl_tb.sv
module step_atten_ctrl_tb;
  localparam int SETTLE = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ctl_n = 6'h3f;
  logic       latch = 1'b0;
  logic       serial_sel = 1'b0;
  logic       pwr_sel0 = 1'b0;
  logic       pwr_sel1 = 1'b0;
  logic [5:0] atten_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  step_atten_ctrl #(.CODE_W(6), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_n(ctl_n), .latch(latch),
    .serial_sel(serial_sel), .pwr_sel0(pwr_sel0), .pwr_sel1(pwr_sel1),
    .atten_code(atten_code)
  );

  task automatic chk(input string req, input logic [5:0] exp);
    checks++;
    if (atten_code !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, atten_code, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic boot(input logic le, input logic [1:0] pup, input logic [5:0] w);
    @(negedge clk);
    rst_n = 1'b0; latch = le; {pwr_sel1, pwr_sel0} = pup; ctl_n = w; serial_sel = 1'b0;
    step(3);
    chk("R1", 6'd0);
    rst_n = 1'b1;
    step(SETTLE + 6);
  endtask

  task automatic t_reset_and_settle();
    @(negedge clk);
    rst_n = 1'b0; latch = 1'b1; ctl_n = 6'b000000;
    step(4);
    chk("R1", 6'd0);
    rst_n = 1'b1;
    step(10);
    chk("R2", 6'd0);
    ctl_n = 6'b010101; serial_sel = 1'b1;
    step(10);
    chk("R2", 6'd0);
    serial_sel = 1'b0; ctl_n = 6'b101010;
    step(SETTLE);
    chk("R4", 6'b010101);
  endtask

  task automatic t_pup_pins();
    logic [5:0] exp [4] = '{6'd63, 6'd48, 6'd32, 6'd0};
    for (int i = 0; i < 4; i++) begin
      boot(1'b0, 2'(i), 6'b110011);
      chk("R3", exp[i]);
    end
  endtask

  task automatic t_direct();
    boot(1'b1, 2'b00, 6'b111111);
    chk("R4", 6'd0);
    ctl_n = 6'b111110;
    step(2);
    chk("R9", 6'd0);
    step(1);
    chk("R9", 6'd1);
    ctl_n = 6'b011111; step(3); chk("R5", 6'd32);
    ctl_n = 6'b000000; step(3); chk("R5", 6'd63);
    ctl_n = 6'b101101; step(3); chk("R5", 6'b010010);
  endtask

  task automatic t_latched();
    boot(1'b1, 2'b00, 6'b110111);
    chk("R4", 6'd8);
    latch = 1'b0; step(3);
    ctl_n = 6'b000011; step(6);
    chk("R6", 6'd8);
    ctl_n = 6'b111100; step(6);
    chk("R6", 6'd8);
    latch = 1'b1; step(2);
    latch = 1'b0; step(3);
    chk("R7", 6'd3);
    ctl_n = 6'b010101; step(6);
    chk("R7", 6'd3);
  endtask

  task automatic t_serial_hold();
    boot(1'b1, 2'b00, 6'b111011);
    chk("R4", 6'd4);
    serial_sel = 1'b1; step(3);
    ctl_n = 6'b000000; step(6);
    chk("R8", 6'd4);
    ctl_n = 6'b011110; step(6);
    chk("R8", 6'd4);
    serial_sel = 1'b0; step(3);
    chk("R5", 6'b100001);
  endtask

  initial begin
    t_reset_and_settle();
    t_pup_pins();
    t_direct();
    t_latched();
    t_serial_hold();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule